// File: doc/BRIEF.md
# Write Status Polling Logic

This block supplies what a host sees on the read bus while a byte or page write into the nonvolatile array is pending or running. A page write controller tells it when the inter-byte load timer is running and when the internally timed program phase is busy, and it passes on every byte the host loads. Each read strobe is answered one clock later on a registered read bus. When no write is pending, the answer is the addressed array byte. When a write is pending, three of the bits report progress and the remaining bits are left undriven.

Three progress indicators appear in one read. The top bit returns the inverse of the top bit of the last loaded byte until the write is over. The next bit flips on every status read. The bit below it tells whether the load timer is still counting or the program phase has begun. A separate ready/busy pin, modelled as an active-low value with its own output enable so that it behaves like an open-drain line, is pulled low for the whole program phase.

Top module: `wr_status_poll`

## Requirements
- R1: With neither the load timer nor the program phase active, a read strobe returns the array byte presented in the strobe cycle, all eight bits driven (`rd_oe` = 8'hFF), on the clock after the strobe.
- R2: While a write is pending, bit 7 of a read returns the inverse of bit 7 of the last loaded byte.
- R3: While a write is pending, bit 6 reads 0 on the first status read and changes on every further status read.
- R4: The bit 6 state returns to 0 when a write cycle ends, so the first status read of the next cycle returns 0 again.
- R5: While a write is pending, bit 5 reads 0 while the load timer runs and 1 once the program phase is busy.
- R6: During a status read, bits 4 to 0 are undriven: `rd_oe` = 8'hE0 and `rd_data[4:0]` = 0.
- R7: Once the program phase has ended, reads again return the array byte with all bits driven.
- R8: `rdy_oe` is 1 with `rdy_n` = 0 on the clock after `wr_busy` is seen high; `rdy_oe` is 0 with `rdy_n` = 1 on the clock after it is seen low.
- R9: Status is reported only after at least one byte has been loaded; a load timer or busy indication with no loaded byte leaves reads returning array data.
- R10: `rd_valid` is 1 exactly on the clock after a cycle with `rd_strobe` high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_wr | input | 1 | A byte is loaded into the page buffer this cycle |
| byte_data | input | 8 | The byte being loaded |
| load_active | input | 1 | Inter-byte load timer is running |
| wr_busy | input | 1 | Internally timed program phase is in progress |
| rd_strobe | input | 1 | Host read request |
| arr_data | input | 8 | Array byte at the addressed location, valid with the strobe |
| rd_valid | output | 1 | Read answer present on the bus |
| rd_data | output | 8 | Read answer |
| rd_oe | output | 8 | Per-bit drive enable for the read answer |
| rdy_n | output | 1 | Ready/busy level, low when busy |
| rdy_oe | output | 1 | Ready/busy drive enable, high only while pulling low |

## Verification
A stuck or wrongly cleared pending flag shows up on the first read after a load or after completion: the host sees either array data where status was due or status where data was due, in the very next read answer. A toggle state that fails to flip or fails to restart is caught by comparing two successive status reads within a cycle and the first read of a following cycle. A ready/busy register that lags or leads is seen one clock after each `wr_busy` edge.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_LOADING = 2'd1,
    PH_PROGRAM = 2'd2
  } phase_e;
endpackage

// File: rtl/wsp_tracker.sv
// Remembers the last loaded byte and whether a write cycle is pending.
module wsp_tracker
  import wsp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              load_active,
  input  logic              wr_busy,
  output phase_e            phase,
  output logic [DATA_W-1:0] last_byte
);
  logic loaded_q;
  logic seen_busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded_q    <= 1'b0;
      seen_busy_q <= 1'b0;
      last_byte   <= '0;
    end else if (byte_wr) begin
      loaded_q    <= 1'b1;
      seen_busy_q <= 1'b0;
      last_byte   <= byte_data;
    end else if (loaded_q && wr_busy) begin
      seen_busy_q <= 1'b1;
    end else if (seen_busy_q && !wr_busy) begin
      // program phase finished: the cycle is over
      loaded_q    <= 1'b0;
      seen_busy_q <= 1'b0;
    end
  end

  always_comb begin
    if (!loaded_q || !(load_active || wr_busy)) phase = PH_IDLE;
    else if (wr_busy)                           phase = PH_PROGRAM;
    else                                        phase = PH_LOADING;
  end
endmodule

// File: rtl/wsp_toggle.sv
// Per-read toggle state; held at zero outside a pending write.
module wsp_toggle
  import wsp_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e phase,
  input  logic   rd_strobe,
  output logic   tog
);
  always_ff @(posedge clk) begin
    if (rst)                    tog <= 1'b0;
    else if (phase == PH_IDLE)  tog <= 1'b0;
    else if (rd_strobe)         tog <= ~tog;
  end
endmodule

// File: rtl/wsp_readmux.sv
// Registered read answer: array byte or status pattern.
module wsp_readmux
  import wsp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6,
  parameter int TMR_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_strobe,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] last_byte,
  input  logic              tog,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rd_oe
);
  logic [DATA_W-1:0] stat_val;
  logic [DATA_W-1:0] stat_oe;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign stat_val[i] = ~last_byte[POLL_BIT];
      assign stat_oe[i]  = 1'b1;
    end else if (i == TOG_BIT) begin : g_tog
      assign stat_val[i] = tog;
      assign stat_oe[i]  = 1'b1;
    end else if (i == TMR_BIT) begin : g_tmr
      assign stat_val[i] = (phase == PH_PROGRAM);
      assign stat_oe[i]  = 1'b1;
    end else begin : g_off
      assign stat_val[i] = 1'b0;
      assign stat_oe[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_oe    <= '0;
    end else begin
      rd_valid <= rd_strobe;
      if (!rd_strobe) begin
        rd_data <= '0;
        rd_oe   <= '0;
      end else if (phase == PH_IDLE) begin
        rd_data <= arr_data;
        rd_oe   <= '1;
      end else begin
        rd_data <= stat_val;
        rd_oe   <= stat_oe;
      end
    end
  end
endmodule

// File: rtl/wsp_readybusy.sv
// Open-drain style ready/busy: drives low while busy, released otherwise.
module wsp_readybusy (
  input  logic clk,
  input  logic rst,
  input  logic wr_busy,
  output logic rdy_n,
  output logic rdy_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n  <= 1'b1;
      rdy_oe <= 1'b0;
    end else begin
      rdy_n  <= ~wr_busy;
      rdy_oe <= wr_busy;
    end
  end
endmodule

// File: rtl/wr_status_poll.sv
module wr_status_poll
  import wsp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int POLL_BIT = DATA_W - 1,
  parameter int TOG_BIT  = DATA_W - 2,
  parameter int TMR_BIT  = DATA_W - 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_wr,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              load_active,
  input  logic              wr_busy,
  input  logic              rd_strobe,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rd_oe,
  output logic              rdy_n,
  output logic              rdy_oe
);
  phase_e            phase;
  logic [DATA_W-1:0] last_byte;
  logic              tog;

  wsp_tracker #(.DATA_W(DATA_W)) u_tracker (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .byte_data(byte_data),
    .load_active(load_active), .wr_busy(wr_busy),
    .phase(phase), .last_byte(last_byte)
  );

  wsp_toggle u_toggle (
    .clk(clk), .rst(rst), .phase(phase), .rd_strobe(rd_strobe), .tog(tog)
  );

  wsp_readmux #(
    .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT), .TMR_BIT(TMR_BIT)
  ) u_readmux (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .phase(phase),
    .last_byte(last_byte), .tog(tog), .arr_data(arr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  wsp_readybusy u_rdy (
    .clk(clk), .rst(rst), .wr_busy(wr_busy), .rdy_n(rdy_n), .rdy_oe(rdy_oe)
  );
endmodule

// File: rtl/wr_status_poll_chk.sv
module wr_status_poll_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load_active,
  input logic              wr_busy,
  input logic              rd_strobe,
  input logic [DATA_W-1:0] arr_data,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] rd_oe,
  input logic              rdy_n,
  input logic              rdy_oe
);
  p_valid_on_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> rd_valid);
  p_no_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> !rd_valid);
  p_rdy_pull_r8: assert property (@(posedge clk) disable iff (rst)
    wr_busy |=> (rdy_oe && !rdy_n));
  p_rdy_release_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_busy |=> (!rdy_oe && rdy_n));
  p_array_read_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !load_active && !wr_busy) |=>
      (rd_oe == {DATA_W{1'b1}} && rd_data == $past(arr_data)));
  p_low_bits_off_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_oe[0]) |-> (rd_oe[DATA_W-4:0] == '0 && rd_data[DATA_W-4:0] == '0));
endmodule

bind wr_status_poll wr_status_poll_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .load_active(load_active), .wr_busy(wr_busy),
  .rd_strobe(rd_strobe), .arr_data(arr_data), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_oe(rd_oe), .rdy_n(rdy_n), .rdy_oe(rdy_oe)
);

// File: tb/wr_status_poll_bench.sv
`timescale 1ns/1ps
module wr_status_poll_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       byte_wr = 1'b0;
  logic [7:0] byte_data = '0;
  logic       load_active = 1'b0;
  logic       wr_busy = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] arr_data = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic [7:0] rd_oe;
  logic       rdy_n;
  logic       rdy_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [7:0] data;
    logic [7:0] oe;
    logic [7:0] tag;
  } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  wr_status_poll u_wr_status_poll (
    .clk(clk), .rst(rst), .byte_wr(byte_wr), .byte_data(byte_data),
    .load_active(load_active), .wr_busy(wr_busy), .rd_strobe(rd_strobe),
    .arr_data(arr_data), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_oe(rd_oe), .rdy_n(rdy_n), .rdy_oe(rdy_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: compare every answer against the scoreboard, away from the edge
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected answer", {rd_data, rd_oe}, 16'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rd_data == e.data && rd_oe == e.oe,
            $sformatf("R%0d read", e.tag), {rd_data, rd_oe}, {e.data, e.oe});
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  // Driver: push expected answer, issue a one-cycle read strobe
  task automatic do_read(input logic [7:0] arr, input logic [7:0] ed,
                         input logic [7:0] eo, input logic [7:0] tag);
    exp_t e;
    e.data = ed; e.oe = eo; e.tag = tag;
    exp_q.push_back(e);
    arr_data  = arr;
    rd_strobe = 1'b1;
    tick(1);
    rd_strobe = 1'b0;
    arr_data  = 8'h00;
    tick(1);
  endtask

  task automatic load_byte(input logic [7:0] b);
    byte_wr = 1'b1; byte_data = b;
    tick(1);
    byte_wr = 1'b0;
    load_active = 1'b1;
    tick(1);
  endtask

  initial begin
    tick(4);
    // reset state
    chk(rd_valid == 1'b0, "R10 reset valid", {15'b0, rd_valid}, 16'h0);
    chk(rdy_oe == 1'b0 && rdy_n == 1'b1, "R8 reset rdy", {14'b0, rdy_oe, rdy_n}, 16'h1);
    rst = 1'b0;
    tick(2);
    chk(rd_valid == 1'b0, "R10 no strobe no answer", {15'b0, rd_valid}, 16'h0);

    // R1 plain array reads
    do_read(8'h3C, 8'h3C, 8'hFF, 8'd1);
    do_read(8'hC3, 8'hC3, 8'hFF, 8'd1);

    // R9 timer/busy without a loaded byte: still array data
    load_active = 1'b1;
    tick(1);
    do_read(8'h77, 8'h77, 8'hFF, 8'd9);
    load_active = 1'b0;
    wr_busy = 1'b1;
    tick(1);
    do_read(8'h5A, 8'h5A, 8'hFF, 8'd9);
    wr_busy = 1'b0;
    tick(2);

    // Cycle 1: load 0xA5 (bit7=1)
    load_byte(8'hA5);
    do_read(8'h11, 8'h00, 8'hE0, 8'd2); // R2 bit7=0, R3 first toggle 0, R5 timer 0, R6
    do_read(8'h11, 8'h40, 8'hE0, 8'd3); // R3 toggled
    load_active = 1'b0;
    wr_busy = 1'b1;
    tick(1);
    chk(rdy_oe == 1'b1 && rdy_n == 1'b0, "R8 busy pull", {14'b0, rdy_oe, rdy_n}, 16'h2);
    do_read(8'h11, 8'h20, 8'hE0, 8'd5); // R5 program phase, toggle back to 0
    // toggle now 1; cycle ends
    wr_busy = 1'b0;
    tick(1);
    chk(rdy_oe == 1'b0 && rdy_n == 1'b1, "R8 release", {14'b0, rdy_oe, rdy_n}, 16'h1);
    tick(1);
    do_read(8'hA5, 8'hA5, 8'hFF, 8'd7); // R7 back to array data

    // Cycle 2: load 0x12 (bit7=0)
    load_byte(8'h12);
    do_read(8'h00, 8'h80, 8'hE0, 8'd4); // R4 toggle restarted at 0, R2 bit7=1
    load_active = 1'b0;
    wr_busy = 1'b1;
    tick(1);
    do_read(8'h00, 8'hE0, 8'hE0, 8'd5); // R5 bit5=1, R3 toggle=1
    do_read(8'h00, 8'hA0, 8'hE0, 8'd3);
    wr_busy = 1'b0;
    tick(2);
    do_read(8'h12, 8'h12, 8'hFF, 8'd7);
    tick(3);
    chk(exp_q.size() == 0, "R10 missing answers", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        chk(1'b0, "watchdog", 16'h0, 16'h1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule